// File: doc/BRIEF.md
# Subroutine-Scoped Color Release Controller

This block ties color-based critical sections to the call structure of a thread. Each thread owns a small array of color slots. When a load or store first touches a color that the thread does not yet hold, the entry logic grants a slot and pulses this block with the slot number. The block then sets that slot's bit in an acquire bitmap, which lists the slots taken inside the subroutine that is running now.

A subroutine prologue issues a call command. The block saves the acquire bitmap on a 16-deep stack and clears it, so the callee starts with an empty record. The epilogue issues a return command. The block copies the acquire bitmap into the release bitmap and restores the caller's saved bitmap from the stack. Software may also write the release bitmap directly. Any release value that is not zero raises a trap that carries the bitmap. The trap handler then gives up those colors and closes their critical sections. The trap stays raised until the handler acknowledges it.

The trap logic is a two-state machine, `TRAP_IDLE` and `TRAP_PEND`, with these transitions:
- RAISE (IDLE→PEND) happens on a release value that is not zero.
- MERGE (PEND→PEND) happens on a release with no acknowledge.
- REPLACE (PEND→PEND) happens on an acknowledge together with a release that is not zero.
- CLEAR (PEND→IDLE) happens on an acknowledge with no new release.
- HOLD (IDLE→IDLE) happens otherwise.

Top module: `cab_exit_ctrl`

## Requirements
- R1: An `acq_valid` pulse with slot index s sets bit s of `acq_bits` on the next clock. Bit i of every bitmap stands for owned-color slot i.
- R2: A call (`call_push` without `ret_pop`) saves the merged acquire bitmap on the stack, clears `acq_bits` to zero and raises `stk_depth` by one.
- R3: A return (`ret_pop` without `call_push`) takes the merged acquire bitmap as the release value, loads `acq_bits` from the top stack entry and lowers `stk_depth` by one.
- R4: A release value that is not zero, coming from a return or from `rel_wr`/`rel_wdata` in TRAP_IDLE, raises `trap_req` on the next clock with `trap_mask` equal to that value.
- R5: A release value of all zeros raises no trap and leaves the trap outputs unchanged.
- R6: `trap_req` and `trap_mask` hold until `trap_ack`. An acknowledge with no new release drops `trap_req` and clears `trap_mask` on the next clock.
- R7: While a trap is pending, a release without acknowledge ORs into `trap_mask`. An acknowledge in the same cycle as a release that is not zero keeps `trap_req` high with `trap_mask` equal to the new value only.
- R8: An acquire pulse in the same cycle as a call is folded into the value that is pushed, and it comes back on the matching return.
- R9: A call at depth 16 stores nothing, sets the sticky `ovf_flag`, keeps `stk_depth` at 16 and still clears `acq_bits`.
- R10: A return at depth 0 sets the sticky `unf_flag` and loads zero into `acq_bits`. The release value is still formed from the merged bitmap.
- R11: `call_push` and `ret_pop` in the same cycle do no stack operation and form no release. Any acquire pulse is still applied to `acq_bits`.
- R12: When a return and `rel_wr` fall in the same cycle, the return's bitmap is taken and `rel_wdata` is dropped.
- R13: After reset, `acq_bits`, `stk_depth`, `trap_req`, `trap_mask`, `ovf_flag` and `unf_flag` are zero and `stk_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | A slot was granted at an entry point |
| acq_slot | input | SLOT_W | Index of the granted slot |
| call_push | input | 1 | Prologue: save and clear the acquire bitmap |
| ret_pop | input | 1 | Epilogue: release and restore the acquire bitmap |
| rel_wr | input | 1 | Direct write to the release bitmap |
| rel_wdata | input | N_SLOTS | Data for a direct release write |
| trap_ack | input | 1 | Handler acknowledge |
| acq_bits | output | N_SLOTS | Current acquire bitmap |
| trap_req | output | 1 | Release trap pending |
| trap_mask | output | N_SLOTS | Slots the handler must release |
| stk_depth | output | CNT_W | Number of saved entries |
| stk_full | output | 1 | Stack holds 16 entries |
| stk_empty | output | 1 | Stack holds no entries |
| ovf_flag | output | 1 | Sticky: call while full |
| unf_flag | output | 1 | Sticky: return while empty |

## Verification
Two pairs of functions can fall in the same cycle: an entry-point acquire with a call or return, and a return's implicit release with a software release write or a handler acknowledge. The vector table drives each pair in one cycle. It then judges the result at the ports one clock later. The folded acquire bit must show up in the bitmap that a later return restores. The return's bitmap, not the written data, must appear in `trap_mask`. An acknowledge that meets a new release must leave the trap raised with only the new bits.

// File: rtl/cab_pkg.sv
package cab_pkg;
    typedef enum logic [0:0] {
        TRAP_IDLE = 1'b0,
        TRAP_PEND = 1'b1
    } trap_state_e;
endpackage

// File: rtl/cab_bitmap_stack.sv
module cab_bitmap_stack #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             ovf,
    output logic             unf
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] top_idx;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign wr_idx  = PTR_W'(count);
    assign top_idx = PTR_W'(count - 1'b1);
    assign rdata   = empty ? '0 : mem[top_idx];

    // storage carries no reset; only entries below count are ever read
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf <= 1'b1;
                else      count <= count + 1'b1;
            end else if (pop) begin
                if (empty) unf <= 1'b1;
                else       count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cab_acq_reg.sv
module cab_acq_reg #(
    parameter int N_SLOTS = 8,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acq_valid,
    input  logic [SLOT_W-1:0]  acq_slot,
    input  logic               do_push,
    input  logic               do_pop,
    input  logic [N_SLOTS-1:0] pop_data,
    output logic [N_SLOTS-1:0] acq_bits,
    output logic [N_SLOTS-1:0] merged
);
    logic [N_SLOTS-1:0] slot_bit;

    assign slot_bit = acq_valid ? ({{(N_SLOTS-1){1'b0}}, 1'b1} << acq_slot) : '0;
    assign merged   = acq_bits | slot_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_bits <= '0;
        end else if (do_push) begin
            acq_bits <= '0;
        end else if (do_pop) begin
            acq_bits <= pop_data;
        end else begin
            acq_bits <= merged;
        end
    end
endmodule

// File: rtl/cab_release_trap.sv
module cab_release_trap
    import cab_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_SLOTS-1:0] wr_data,
    input  logic               ack,
    output logic               trap_req,
    output logic [N_SLOTS-1:0] trap_mask
);
    trap_state_e state_q, state_d;
    logic [N_SLOTS-1:0] mask_d;
    logic               live;

    assign live = wr_en && (wr_data != '0);

    always_comb begin
        state_d = state_q;
        mask_d  = trap_mask;
        unique case (state_q)
            TRAP_IDLE: begin
                if (live) begin          // RAISE
                    state_d = TRAP_PEND;
                    mask_d  = wr_data;
                end
            end
            TRAP_PEND: begin
                if (ack && live) begin   // REPLACE
                    mask_d = wr_data;
                end else if (ack) begin  // CLEAR
                    state_d = TRAP_IDLE;
                    mask_d  = '0;
                end else if (live) begin // MERGE
                    mask_d = trap_mask | wr_data;
                end
            end
            default: begin
                state_d = TRAP_IDLE;
                mask_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRAP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trap_mask <= '0;
        else        trap_mask <= mask_d;
    end

    assign trap_req = (state_q == TRAP_PEND);
endmodule

// File: rtl/cab_exit_ctrl.sv
module cab_exit_ctrl #(
    parameter int N_SLOTS     = 8,
    parameter int STACK_DEPTH = 16,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int CNT_W  = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acq_valid,
    input  logic [SLOT_W-1:0]  acq_slot,
    input  logic               call_push,
    input  logic               ret_pop,
    input  logic               rel_wr,
    input  logic [N_SLOTS-1:0] rel_wdata,
    input  logic               trap_ack,
    output logic [N_SLOTS-1:0] acq_bits,
    output logic               trap_req,
    output logic [N_SLOTS-1:0] trap_mask,
    output logic [CNT_W-1:0]   stk_depth,
    output logic               stk_full,
    output logic               stk_empty,
    output logic               ovf_flag,
    output logic               unf_flag
);
    logic               do_push;
    logic               do_pop;
    logic [N_SLOTS-1:0] merged;
    logic [N_SLOTS-1:0] saved;
    logic               rel_en;
    logic [N_SLOTS-1:0] rel_val;

    // simultaneous call and return cancel each other
    assign do_push = call_push && !ret_pop;
    assign do_pop  = ret_pop && !call_push;

    // an epilogue release takes precedence over a direct write
    assign rel_en  = do_pop || rel_wr;
    assign rel_val = do_pop ? merged : rel_wdata;

    cab_acq_reg #(.N_SLOTS(N_SLOTS)) u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_valid(acq_valid),
        .acq_slot (acq_slot),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .pop_data (saved),
        .acq_bits (acq_bits),
        .merged   (merged)
    );

    cab_bitmap_stack #(.WIDTH(N_SLOTS), .DEPTH(STACK_DEPTH)) u_stack (
        .clk  (clk),
        .rst_n(rst_n),
        .push (do_push),
        .pop  (do_pop),
        .wdata(merged),
        .rdata(saved),
        .count(stk_depth),
        .full (stk_full),
        .empty(stk_empty),
        .ovf  (ovf_flag),
        .unf  (unf_flag)
    );

    cab_release_trap #(.N_SLOTS(N_SLOTS)) u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rel_en),
        .wr_data  (rel_val),
        .ack      (trap_ack),
        .trap_req (trap_req),
        .trap_mask(trap_mask)
    );
endmodule

// File: rtl/cab_exit_chk.sv
module cab_exit_chk #(
    parameter int N_SLOTS     = 8,
    parameter int STACK_DEPTH = 16,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int CNT_W  = $clog2(STACK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acq_valid,
    input logic [SLOT_W-1:0]  acq_slot,
    input logic               call_push,
    input logic               ret_pop,
    input logic               rel_wr,
    input logic [N_SLOTS-1:0] rel_wdata,
    input logic               trap_ack,
    input logic [N_SLOTS-1:0] acq_bits,
    input logic               trap_req,
    input logic [N_SLOTS-1:0] trap_mask,
    input logic [CNT_W-1:0]   stk_depth,
    input logic               stk_empty,
    input logic               ovf_flag
);
    AST_ACQ_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_valid && !call_push && !ret_pop) |=> acq_bits[$past(acq_slot)]); // R1

    AST_CALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (call_push && !ret_pop) |=> (acq_bits == '0)); // R2

    AST_TRAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_mask != '0)); // R4

    AST_ZERO_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && rel_wr && (rel_wdata == '0) && !(ret_pop && !call_push)) |=> !trap_req); // R5

    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> (trap_req && ((trap_mask & $past(trap_mask)) == $past(trap_mask)))); // R6

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= CNT_W'(STACK_DEPTH)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R9

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pop && !call_push && stk_empty) |=> (acq_bits == '0)); // R10
endmodule

bind cab_exit_ctrl cab_exit_chk #(.N_SLOTS(N_SLOTS), .STACK_DEPTH(STACK_DEPTH)) u_exit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_valid(acq_valid),
    .acq_slot (acq_slot),
    .call_push(call_push),
    .ret_pop  (ret_pop),
    .rel_wr   (rel_wr),
    .rel_wdata(rel_wdata),
    .trap_ack (trap_ack),
    .acq_bits (acq_bits),
    .trap_req (trap_req),
    .trap_mask(trap_mask),
    .stk_depth(stk_depth),
    .stk_empty(stk_empty),
    .ovf_flag (ovf_flag)
);

// File: tb/test_cab_exit_ctrl.sv
module test_cab_exit_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acq_valid, call_push, ret_pop, rel_wr, trap_ack;
    logic [2:0] acq_slot;
    logic [7:0] rel_wdata;
    logic [7:0] acq_bits, trap_mask;
    logic       trap_req, stk_full, stk_empty, ovf_flag, unf_flag;
    logic [4:0] stk_depth;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cab_exit_ctrl i_cab_exit_ctrl (
        .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_slot(acq_slot),
        .call_push(call_push), .ret_pop(ret_pop), .rel_wr(rel_wr),
        .rel_wdata(rel_wdata), .trap_ack(trap_ack), .acq_bits(acq_bits),
        .trap_req(trap_req), .trap_mask(trap_mask), .stk_depth(stk_depth),
        .stk_full(stk_full), .stk_empty(stk_empty), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag)
    );

    typedef struct packed {
        logic       av;
        logic [2:0] sl;
        logic       pu;
        logic       po;
        logic       rw;
        logic [7:0] rd;
        logic       ak;
        logic [7:0] e_acq;
        logic [4:0] e_dep;
        logic       e_trap;
        logic [7:0] e_mask;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h04, 5'd0, 1'b0, 8'h00},
        '{1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h24, 5'd0, 1'b0, 8'h00},
        '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 5'd1, 1'b0, 8'h00},
        '{1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80, 5'd1, 1'b0, 8'h00},
        '{1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h25, 5'd0, 1'b1, 8'h80},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h25, 5'd0, 1'b1, 8'h80},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h25, 5'd0, 1'b0, 8'h00},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h25, 5'd0, 1'b0, 8'h00},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 8'h25, 5'd0, 1'b1, 8'h03},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0, 8'h25, 5'd0, 1'b1, 8'h13},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h40, 1'b1, 8'h25, 5'd0, 1'b1, 8'h40},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h25, 5'd0, 1'b0, 8'h00},
        '{1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h27, 5'd0, 1'b0, 8'h00},
        '{1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h0F, 1'b0, 8'h00, 5'd0, 1'b1, 8'h27},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 5'd0, 1'b0, 8'h00}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 3:     return "R1";
            2:           return "R2/R8";
            4:           return "R3/R8";
            5, 6, 11, 14: return "R6";
            7:           return "R5";
            8:           return "R4";
            9, 10:       return "R7";
            12:          return "R11";
            default:     return "R10/R12";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acq_valid = 1'b0; acq_slot = '0; call_push = 1'b0; ret_pop = 1'b0;
        rel_wr = 1'b0; rel_wdata = '0; trap_ack = 1'b0;
    endtask

    // drive on the falling edge, let one rising edge pass, sample 2 ns later
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R13 reset state
        chk("R13", "acq_bits", 32'(acq_bits), 32'h0);
        chk("R13", "stk_depth", 32'(stk_depth), 32'h0);
        chk("R13", "trap_req", 32'(trap_req), 32'h0);
        chk("R13", "trap_mask", 32'(trap_mask), 32'h0);
        chk("R13", "ovf_flag", 32'(ovf_flag), 32'h0);
        chk("R13", "unf_flag", 32'(unf_flag), 32'h0);
        chk("R13", "stk_empty", 32'(stk_empty), 32'h1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acq_valid = TBL[i].av; acq_slot = TBL[i].sl;
            call_push = TBL[i].pu; ret_pop = TBL[i].po;
            rel_wr = TBL[i].rw; rel_wdata = TBL[i].rd; trap_ack = TBL[i].ak;
            step();
            chk(tag_of(i), $sformatf("step %0d acq_bits", i), 32'(acq_bits), 32'(TBL[i].e_acq));
            chk(tag_of(i), $sformatf("step %0d stk_depth", i), 32'(stk_depth), 32'(TBL[i].e_dep));
            chk(tag_of(i), $sformatf("step %0d trap_req", i), 32'(trap_req), 32'(TBL[i].e_trap));
            chk(tag_of(i), $sformatf("step %0d trap_mask", i), 32'(trap_mask), 32'(TBL[i].e_mask));
        end
        @(negedge clk);
        idle_inputs();
        chk("R10", "unf_flag after empty return", 32'(unf_flag), 32'h1);
        chk("R9", "ovf_flag before overflow", 32'(ovf_flag), 32'h0);

        // R9: sixteen calls fill the stack, the seventeenth overflows
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            idle_inputs();
            acq_valid = 1'b1; acq_slot = 3'(k % 8); call_push = 1'b1;
            step();
        end
        chk("R9", "stk_depth at overflow", 32'(stk_depth), 32'd16);
        chk("R9", "stk_full", 32'(stk_full), 32'h1);
        chk("R9", "ovf_flag", 32'(ovf_flag), 32'h1);
        chk("R9", "acq_bits cleared by overflowing call", 32'(acq_bits), 32'h0);

        // R3/R8: returns bring back the saved one-hot entries, newest first
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            idle_inputs();
            ret_pop = 1'b1; trap_ack = 1'b1;
            step();
            chk("R3", $sformatf("restore %0d acq_bits", k), 32'(acq_bits), 32'(8'h01 << ((15 - k) % 8)));
        end
        chk("R3", "stk_depth after unwinding", 32'(stk_depth), 32'd0);
        chk("R9", "ovf_flag stays set", 32'(ovf_flag), 32'h1);

        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        step();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R13", "ovf_flag after reset", 32'(ovf_flag), 32'h0);
        chk("R13", "unf_flag after reset", 32'(unf_flag), 32'h0);
        chk("R13", "trap_req after reset", 32'(trap_req), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule